// File: doc/BRIEF.md
# Strided Stream Prefetcher

This block watches the stream of cache-miss line addresses and learns, per 4 KB page, whether the misses walk through memory with a constant stride. It tracks several pages at once, one stream per page. A stream begins learning only after two misses in its page that are less than 256 bytes apart. It is confirmed when a third miss repeats the same stride. From then on it issues prefetch line addresses further along that stride.

A confirmed stream runs a fixed number of prefetches ahead of the newest miss. It stops when it reaches that distance or the edge of its page. Each further miss that follows the stride lets it issue one more. Requests leave through a registered valid/ready port, one per cycle, taken in turn from the streams that are able to issue. A miss to a page that no stream holds takes a free stream if one exists, and otherwise replaces the stream that has gone longest without a miss.

Top module: `strpf_top`

## Requirements
- R1: After reset `pf_valid` is low, and no prefetch appears until a stream has been confirmed.
- R2: Misses to lines b, b+N and b+2N of one page, with N nonzero and |N| below 4 lines (256 bytes at 64-byte lines), confirm the stream. The first prefetch is line b+3N, and later prefetches continue at stride N.
- R3: A second miss 256 bytes or more from the previous miss of its page does not start learning. It becomes the new reference for the next miss.
- R4: A confirmed stream holds at most 12 issued prefetches beyond its newest miss. Each further miss that matches the stride allows exactly one more prefetch.
- R5: A prefetch whose line would leave the stream's 4 KB page is never issued.
- R6: A miss to the same line as the previous miss of its stream changes nothing.
- R7: In a confirmed stream, a miss at a different stride under 256 bytes sends the stream back to learning with the new stride. One more miss at that stride confirms it again.
- R8: Up to 8 pages are tracked. A miss to a new page uses a free stream if one exists, and otherwise replaces the stream whose last miss is oldest.
- R9: At most one prefetch is issued per cycle, taken round-robin across the streams that can issue.
- R10: While `pf_valid` is high and `pf_ready` is low, `pf_valid` and `pf_line` hold their values.
- R11: Streams in different pages train and run independently. Activity in one page does not disturb the stride or run-ahead position of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| miss_valid | input | 1 | A miss line address is presented this cycle |
| miss_line | input | 26 | Miss line address (byte address divided by 64); bits 25:6 give the page, bits 5:0 the line in the page |
| pf_ready | input | 1 | The consumer accepts the prefetch request this cycle |
| pf_valid | output | 1 | A prefetch request is presented |
| pf_line | output | 26 | Line address to prefetch |

## Verification
The miss sequences cover several cases. An ascending unit stride shows confirmation and the 12-line run-ahead limit. A descending stride of two lines near the bottom of a page shows the page-edge cut-off. A jump of exactly 256 bytes shows that such a jump is refused as a training step. A repeated line followed by a stride change tells apart a miss that is ignored from one that retrains. Interleaving pages shows that streams stay independent. A second stream trained while the consumer stalls exposes the request hold and the round-robin order. Filling all eight streams and then touching the oldest one checks that the victim is chosen by age of last miss rather than by slot order.

// File: rtl/strpf_pkg.sv
package strpf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEEN   = 2'd1,
    ST_TRAIN  = 2'd2,
    ST_STEADY = 2'd3
  } strm_st_e;
endpackage

// File: rtl/strpf_stream.sv
module strpf_stream
  import strpf_pkg::*;
#(
  parameter int OFF_W     = 6,
  parameter int PG_W      = 20,
  parameter int SPAN_L    = 4,
  parameter int RUN_AHEAD = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             alloc,
  input  logic             take,
  input  logic [PG_W-1:0]  pg_in,
  input  logic [OFF_W-1:0] off_in,
  output logic             valid_o,
  output logic             steady_o,
  output logic             elig_o,
  output logic [PG_W-1:0]  pg_o,
  output logic [OFF_W-1:0] pf_off_o
);
  localparam int SD_W  = OFF_W + 2;
  localparam int CNT_W = $clog2(RUN_AHEAD + 1);

  strm_st_e                st_q, st_d;
  logic [PG_W-1:0]         pg_q, pg_d;
  logic [OFF_W-1:0]        last_q, last_d;
  logic signed [SD_W-1:0]  stride_q, stride_d;
  logic signed [SD_W-1:0]  pf_q, pf_d;
  logic [CNT_W-1:0]        ahead_q, ahead_d;

  logic signed [SD_W-1:0]  off_s, last_s, delta;
  logic [SD_W-1:0]         mag;
  logic                    near;
  logic                    en;

  assign off_s  = $signed({2'b00, off_in});
  assign last_s = $signed({2'b00, last_q});
  assign delta  = off_s - last_s;
  assign mag    = delta[SD_W-1] ? $unsigned(-delta) : $unsigned(delta);
  assign near   = (delta != '0) && (mag < SD_W'(SPAN_L));
  assign en     = alloc | upd | take;

  always_comb begin
    st_d     = st_q;
    pg_d     = pg_q;
    last_d   = last_q;
    stride_d = stride_q;
    pf_d     = pf_q;
    ahead_d  = ahead_q;
    if (alloc) begin
      st_d     = ST_SEEN;
      pg_d     = pg_in;
      last_d   = off_in;
      stride_d = '0;
      pf_d     = '0;
      ahead_d  = '0;
    end else if (upd && (delta != '0)) begin
      last_d = off_in;
      case (st_q)
        ST_SEEN: begin
          if (near) begin
            st_d     = ST_TRAIN;
            stride_d = delta;
          end
        end
        ST_TRAIN: begin
          if (delta == stride_q) begin
            st_d    = ST_STEADY;
            pf_d    = off_s + stride_q;
            ahead_d = '0;
          end else if (near) begin
            stride_d = delta;
          end else begin
            st_d = ST_SEEN;
          end
        end
        ST_STEADY: begin
          if (delta == stride_q) begin
            if (ahead_q != '0) ahead_d = ahead_q - CNT_W'(1);
            else               pf_d    = pf_q + stride_q;
          end else if (near) begin
            st_d     = ST_TRAIN;
            stride_d = delta;
          end else begin
            st_d = ST_SEEN;
          end
        end
        default: ;
      endcase
    end else if (take) begin
      pf_d    = pf_q + stride_q;
      ahead_d = ahead_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      pg_q     <= '0;
      last_q   <= '0;
      stride_q <= '0;
      pf_q     <= '0;
      ahead_q  <= '0;
    end else if (en) begin
      st_q     <= st_d;
      pg_q     <= pg_d;
      last_q   <= last_d;
      stride_q <= stride_d;
      pf_q     <= pf_d;
      ahead_q  <= ahead_d;
    end
  end

  assign valid_o  = (st_q != ST_IDLE);
  assign steady_o = (st_q == ST_STEADY);
  assign elig_o   = steady_o && (ahead_q < CNT_W'(RUN_AHEAD)) &&
                    !pf_q[SD_W-1] && (pf_q[SD_W-2:OFF_W] == '0);
  assign pg_o     = pg_q;
  assign pf_off_o = pf_q[OFF_W-1:0];
endmodule

// File: rtl/strpf_rr.sv
module strpf_rr #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          gnt_vld,
  output logic [IW-1:0] gnt_idx
);
  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(ptr) + k) % N;
      if (!gnt_vld && req[j]) begin
        gnt_vld = 1'b1;
        gnt_idx = IW'(j);
      end
    end
  end
endmodule

// File: rtl/strpf_top.sv
module strpf_top #(
  parameter int ADDR_W     = 32,
  parameter int LINE_B     = 6,
  parameter int PAGE_B     = 12,
  parameter int NSTR       = 8,
  parameter int RUN_AHEAD  = 12,
  parameter int TRAIN_SPAN = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     miss_valid,
  input  logic [ADDR_W-LINE_B-1:0] miss_line,
  input  logic                     pf_ready,
  output logic                     pf_valid,
  output logic [ADDR_W-LINE_B-1:0] pf_line
);
  localparam int LA_W   = ADDR_W - LINE_B;
  localparam int OFF_W  = PAGE_B - LINE_B;
  localparam int PG_W   = ADDR_W - PAGE_B;
  localparam int SPAN_L = TRAIN_SPAN >> LINE_B;
  localparam int IW     = (NSTR > 1) ? $clog2(NSTR) : 1;

  // reset synchroniser: asynchronous assert, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [PG_W-1:0]  miss_pg;
  logic [OFF_W-1:0] miss_off;
  assign miss_pg  = miss_line[LA_W-1:OFF_W];
  assign miss_off = miss_line[OFF_W-1:0];

  logic [NSTR-1:0]  s_valid, s_steady, s_elig;
  logic [PG_W-1:0]  s_pg [NSTR];
  logic [OFF_W-1:0] s_pf [NSTR];
  logic [NSTR-1:0]  upd_vec, alloc_vec, take_vec;
  logic [IW-1:0]    rank_q [NSTR];
  logic [IW-1:0]    rank_d [NSTR];

  logic          hit_any, free_any;
  logic [IW-1:0] hit_idx, free_idx, old_idx, sel_idx;

  // page lookup and victim choice
  always_comb begin
    hit_any  = 1'b0;
    hit_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    old_idx  = '0;
    for (int i = 0; i < NSTR; i++) begin
      if (!hit_any && s_valid[i] && (s_pg[i] == miss_pg)) begin
        hit_any = 1'b1;
        hit_idx = IW'(i);
      end
      if (!free_any && !s_valid[i]) begin
        free_any = 1'b1;
        free_idx = IW'(i);
      end
      if (rank_q[i] == IW'(NSTR - 1)) old_idx = IW'(i);
    end
    sel_idx = hit_any ? hit_idx : (free_any ? free_idx : old_idx);
  end

  // age ranking: 0 is the most recent miss, NSTR-1 the oldest
  always_comb begin
    for (int i = 0; i < NSTR; i++) begin
      rank_d[i] = rank_q[i];
      if (IW'(i) == sel_idx)                rank_d[i] = '0;
      else if (rank_q[i] < rank_q[sel_idx]) rank_d[i] = rank_q[i] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int i = 0; i < NSTR; i++) rank_q[i] <= IW'(i);
    end else if (miss_valid) begin
      for (int i = 0; i < NSTR; i++) rank_q[i] <= rank_d[i];
    end
  end

  // issue path
  logic          load, issue, gnt_vld;
  logic [IW-1:0] gnt_idx, rr_q, rr_d;
  logic          pf_valid_q;
  logic [LA_W-1:0] pf_line_q;

  assign load  = !pf_valid_q || pf_ready;
  assign issue = load && gnt_vld;
  assign rr_d  = (gnt_idx == IW'(NSTR - 1)) ? '0 : gnt_idx + 1'b1;

  strpf_rr #(.N(NSTR), .IW(IW)) u_rr (
    .req     (s_elig & ~upd_vec),
    .ptr     (rr_q),
    .gnt_vld (gnt_vld),
    .gnt_idx (gnt_idx)
  );

  for (genvar g = 0; g < NSTR; g++) begin : g_strm
    assign upd_vec[g]   = miss_valid && (sel_idx == IW'(g));
    assign alloc_vec[g] = upd_vec[g] && !hit_any;
    assign take_vec[g]  = issue && (gnt_idx == IW'(g));

    strpf_stream #(
      .OFF_W(OFF_W), .PG_W(PG_W), .SPAN_L(SPAN_L), .RUN_AHEAD(RUN_AHEAD)
    ) u_strm (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .upd      (upd_vec[g]),
      .alloc    (alloc_vec[g]),
      .take     (take_vec[g]),
      .pg_in    (miss_pg),
      .off_in   (miss_off),
      .valid_o  (s_valid[g]),
      .steady_o (s_steady[g]),
      .elig_o   (s_elig[g]),
      .pg_o     (s_pg[g]),
      .pf_off_o (s_pf[g])
    );
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pf_valid_q <= 1'b0;
      pf_line_q  <= '0;
    end else if (load) begin
      pf_valid_q <= gnt_vld;
      if (gnt_vld) pf_line_q <= {s_pg[gnt_idx], s_pf[gnt_idx]};
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rr_q <= '0;
    else if (issue)   rr_q <= rr_d;
  end

  assign pf_valid = pf_valid_q;
  assign pf_line  = pf_line_q;
endmodule

// File: rtl/strpf_chk.sv
module strpf_chk #(
  parameter int NSTR = 8,
  parameter int LA_W = 26
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pf_valid,
  input logic            pf_ready,
  input logic [LA_W-1:0] pf_line,
  input logic [NSTR-1:0] take_vec,
  input logic [NSTR-1:0] upd_vec,
  input logic [NSTR-1:0] steady_vec
);
  // R10
  pf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_line)));

  // R9
  one_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_vec));

  // R9
  no_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((take_vec & upd_vec) == '0));

  // R8
  one_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_vec));

  // R2
  steady_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((take_vec & ~steady_vec) == '0));
endmodule

bind strpf_top strpf_chk #(.NSTR(NSTR), .LA_W(ADDR_W - LINE_B)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .pf_valid   (pf_valid),
  .pf_ready   (pf_ready),
  .pf_line    (pf_line),
  .take_vec   (take_vec),
  .upd_vec    (upd_vec),
  .steady_vec (s_steady)
);

// File: tb/tb_strpf_top.sv
module tb_strpf_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [25:0] miss_line = '0;
  logic        pf_ready = 1'b0;
  logic        pf_valid;
  logic [25:0] pf_line;

  int n_chk = 0;
  int n_err = 0;
  int n_pf;
  logic [31:0] first_pf;

  always #10 clk = ~clk;

  strpf_top dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_line(miss_line),
    .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_line(pf_line)
  );

  // byte address, expected prefetch count, expected first prefetch byte address
  localparam logic [95:0] VEC [16] = '{
    {32'h1000_0000, 32'd0,  32'h0},
    {32'h1000_0040, 32'd0,  32'h0},
    {32'h1000_0080, 32'd12, 32'h1000_00C0},
    {32'h1000_00C0, 32'd1,  32'h1000_03C0},
    {32'h2000_0300, 32'd0,  32'h0},
    {32'h2000_0280, 32'd0,  32'h0},
    {32'h2000_0200, 32'd4,  32'h2000_0180},
    {32'h3000_0000, 32'd0,  32'h0},
    {32'h3000_0100, 32'd0,  32'h0},
    {32'h3000_0140, 32'd0,  32'h0},
    {32'h3000_0180, 32'd12, 32'h3000_01C0},
    {32'h3000_0180, 32'd0,  32'h0},
    {32'h3000_01C0, 32'd1,  32'h3000_04C0},
    {32'h3000_0240, 32'd0,  32'h0},
    {32'h3000_02C0, 32'd12, 32'h3000_0340},
    {32'h1000_0100, 32'd1,  32'h1000_0400}
  };

  function automatic string vec_req(input int i);
    case (i)
      3:        return "R4";
      6:        return "R5";
      8, 9:     return "R3";
      11, 12:   return "R6";
      13, 14:   return "R7";
      15:       return "R11";
      default:  return "R2";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; miss_valid = 1'b0; pf_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // one miss, then watch the output port for ncyc cycles
  task automatic miss_collect(input logic [31:0] a, input int ncyc);
    @(negedge clk);
    miss_valid = 1'b1;
    miss_line  = a[31:6];
    n_pf = 0;
    first_pf = '0;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      miss_valid = 1'b0;
      if (pf_valid && pf_ready) begin
        if (n_pf == 0) first_pf = {pf_line, 6'd0};
        n_pf++;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R1 watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] held;
    logic [31:0] got [4];

    // R1: reset state
    do_reset();
    check("R1 pf_valid after reset", {31'd0, pf_valid}, 32'd0);

    // vector table walk
    pf_ready = 1'b1;
    for (int i = 0; i < 16; i++) begin
      miss_collect(VEC[i][95:64], 20);
      check(vec_req(i), n_pf, VEC[i][63:32]);
      if (VEC[i][63:32] != 0) check(vec_req(i), first_pf, VEC[i][31:0]);
    end

    // R9 / R10: round-robin order and hold under back-pressure
    do_reset();
    pf_ready = 1'b0;
    miss_collect(32'h4000_0000, 1);
    miss_collect(32'h4000_0040, 1);
    miss_collect(32'h4000_0080, 3);
    check("R10 valid under stall", {31'd0, pf_valid}, 32'd1);
    held = {pf_line, 6'd0};
    check("R10 first request", held, 32'h4000_00C0);
    miss_collect(32'h5000_0000, 1);
    miss_collect(32'h5000_0040, 1);
    miss_collect(32'h5000_0080, 4);
    check("R10 valid held", {31'd0, pf_valid}, 32'd1);
    check("R10 line held", {pf_line, 6'd0}, held);
    pf_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      got[k] = pf_valid ? {pf_line, 6'd0} : 32'hFFFF_FFFF;
      @(negedge clk);
    end
    check("R9 order 0", got[0], 32'h4000_00C0);
    check("R9 order 1", got[1], 32'h5000_00C0);
    check("R9 order 2", got[2], 32'h4000_0100);
    check("R9 order 3", got[3], 32'h5000_0100);

    // R8: replacement by age of last miss
    do_reset();
    pf_ready = 1'b1;
    for (int p = 0; p < 8; p++) miss_collect(32'h6000_0000 + 32'(p) * 32'h1000, 2);
    miss_collect(32'h6000_0040, 2);
    miss_collect(32'h6800_0000, 2);
    miss_collect(32'h6000_0080, 20);
    check("R8 touched stream kept", n_pf, 32'd12);
    check("R8 touched stream first", first_pf, 32'h6000_00C0);
    miss_collect(32'h6000_1040, 2);
    miss_collect(32'h6000_1080, 20);
    check("R8 oldest stream replaced", n_pf, 32'd0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule